// File: doc/BRIEF.md
# Coin-Accumulating Vending Controller

This controller sits behind a single coin slot that takes 5-cent and 10-cent coins. It counts the value deposited. Once the total reaches 15 cents or more, it raises a one-cycle release pulse to let one item out. No change is returned, so any amount over the price is absorbed. Credit is held in units of 5 cents. The default state set has four levels: 0, 5, 10 and 15 cents, encoded in binary as 00, 01, 10 and 11.

The coin sensor gives two one-cycle synchronous strobes, one per coin kind. A cycle in which both strobes are high counts as no coin. The parameter `MEALY_OUT` selects how the release pulse is produced:

- **`MEALY_OUT = 0` (state-based form).** The pulse comes from a register. It is high in the cycle after the completing coin, while the machine sits in the 15-cent state.
- **`MEALY_OUT = 1` (transition form).** The pulse is high in the same cycle as the completing coin strobe. Credit then returns straight to zero, and the 15-cent state is never entered.

Coin values and the price are parameters, given in 5-cent units: `NICKEL_UNITS`, `DIME_UNITS` and `PRICE_UNITS`.

Top module: `vend_ctrl`

## Requirements
- R1: Reset is synchronous and active high, and it forces credit to 0. In the state-based form, the release output is low from the first clock edge at which reset is sampled high. In the transition form, the release output is low in every cycle in which reset is high.
- R2: State-based form: three 5-cent coins raise the release output in the cycle right after the clock edge that samples the third coin.
- R3: Any ordering of one 5-cent and one 10-cent coin completes a purchase.
- R4: Two 10-cent coins complete a purchase. The extra 5 cents is dropped, and the next purchase starts from 0 credit.
- R5: In the state-based form, the release output is high for exactly one cycle. Credit is back at 0 on the following clock edge.
- R6: State-based form: a coin sampled at the clock edge that leaves the 15-cent state is discarded.
- R7: A cycle with both strobes high adds no credit.
- R8: Transition form: the release output is high only in a cycle with exactly one coin strobe whose value brings the credit to the price or above.
- R9: Cycles without a coin keep the credit unchanged.
- R10: Transition form: credit is 0 right after a release, and a coin in the next cycle counts toward the next purchase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nickel | input | 1 | One-cycle strobe: a 5-cent coin was sensed |
| dime | input | 1 | One-cycle strobe: a 10-cent coin was sensed |
| open_o | output | 1 | Release pulse for one item |

## Verification
In the state-based form, a new coin can arrive in the same cycle as the release pulse. In that cycle the return to zero credit competes with the coin's credit. The bench provokes this with back-to-back coin sequences, where a coin lands exactly in the release cycle. It then judges the outcome from the release timing of later coins. In both forms, reset can also coincide with a completing coin. The bench holds a strobe high together with reset and expects no pulse and zero credit afterwards.

// File: rtl/vend_pkg.sv
package vend_pkg;
  typedef enum logic [1:0] {
    COIN_NONE   = 2'd0,
    COIN_NICKEL = 2'd1,
    COIN_DIME   = 2'd2,
    COIN_CLASH  = 2'd3
  } coin_e;
endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
#(
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned SW           = 2
) (
  input  logic          nickel,
  input  logic          dime,
  output logic [SW-1:0] step
);
  coin_e kind;

  always_comb begin
    kind = coin_e'({dime, nickel});
    unique case (kind)
      COIN_NICKEL: step = SW'(NICKEL_UNITS);
      COIN_DIME:   step = SW'(DIME_UNITS);
      default:     step = '0; // idle or clash (R7): no credit
    endcase
  end
endmodule

// File: rtl/vend_credit_tracker.sv
module vend_credit_tracker #(
  parameter int unsigned PRICE_UNITS = 3,
  parameter int unsigned SW          = 2,
  parameter int unsigned CW          = 2,
  parameter bit          MEALY_OUT   = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [SW-1:0] step,
  output logic [CW-1:0] credit,
  output logic          reach
);
  localparam int unsigned   AW   = $clog2(PRICE_UNITS + (1 << SW));
  localparam logic [CW-1:0] FULL = CW'(PRICE_UNITS);
  localparam logic [CW-1:0] LAND = MEALY_OUT ? '0 : FULL;

  logic [AW-1:0] sum;
  logic [CW-1:0] credit_nx;

  always_comb begin
    sum   = AW'(credit) + AW'(step);
    reach = (step != '0) && (sum >= AW'(PRICE_UNITS)) && (credit != FULL);
    if (credit == FULL)   credit_nx = '0;
    else if (reach)       credit_nx = LAND;
    else                  credit_nx = CW'(sum);
  end

  always_ff @(posedge clk) begin
    if (rst) credit <= '0;
    else     credit <= credit_nx;
  end

  // R5: the full level lasts one cycle
  p_full_returns_r5: assert property (@(posedge clk) disable iff (rst)
    (credit == FULL) |=> (credit == '0));
  // R9: idle cycles hold credit
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (rst)
    ((step == '0) && (credit != FULL)) |=> $stable(credit));

  generate
    if (MEALY_OUT) begin : g_ml_chk
      // R8: transition form never parks at the price level
      p_no_full_level_r8: assert property (@(posedge clk) disable iff (rst)
        (credit != FULL));
    end
  endgenerate
endmodule

// File: rtl/vend_open_stage.sv
module vend_open_stage #(
  parameter bit MEALY_OUT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic reach,
  output logic open_o
);
  generate
    if (MEALY_OUT) begin : g_mealy
      assign open_o = reach & ~rst;
    end else begin : g_moore
      logic open_q;
      always_ff @(posedge clk) begin
        if (rst) open_q <= 1'b0;
        else     open_q <= reach;
      end
      assign open_o = open_q;
    end
  endgenerate
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl #(
  parameter int unsigned NICKEL_UNITS = 1,
  parameter int unsigned DIME_UNITS   = 2,
  parameter int unsigned PRICE_UNITS  = 3,
  parameter bit          MEALY_OUT    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel,
  input  logic dime,
  output logic open_o
);
  localparam int unsigned MAXC = (NICKEL_UNITS > DIME_UNITS) ? NICKEL_UNITS : DIME_UNITS;
  localparam int unsigned SW   = $clog2(MAXC + 1);
  localparam int unsigned CW   = $clog2(PRICE_UNITS + 1);
  localparam logic [CW-1:0] FULL = CW'(PRICE_UNITS);

  logic [SW-1:0] step;
  logic [CW-1:0] credit;
  logic          reach;

  vend_coin_decode #(
    .NICKEL_UNITS(NICKEL_UNITS), .DIME_UNITS(DIME_UNITS), .SW(SW)
  ) u_dec (
    .nickel(nickel), .dime(dime), .step(step)
  );

  vend_credit_tracker #(
    .PRICE_UNITS(PRICE_UNITS), .SW(SW), .CW(CW), .MEALY_OUT(MEALY_OUT)
  ) u_trk (
    .clk(clk), .rst(rst), .step(step), .credit(credit), .reach(reach)
  );

  vend_open_stage #(.MEALY_OUT(MEALY_OUT)) u_open (
    .clk(clk), .rst(rst), .reach(reach), .open_o(open_o)
  );

  // R7: clashing strobes leave credit untouched
  p_clash_holds_r7: assert property (@(posedge clk) disable iff (rst)
    (nickel && dime && (credit != FULL)) |=> $stable(credit));

  generate
    if (MEALY_OUT) begin : g_ml_props
      // R1: no release while reset is high
      p_reset_quiet_r1: assert property (@(posedge clk) rst |-> !open_o);
      // R8: release only alongside a single strobe
      p_open_on_coin_r8: assert property (@(posedge clk) disable iff (rst)
        open_o |-> (nickel ^ dime));
      // R10: credit empties after a release
      p_open_clears_r10: assert property (@(posedge clk) disable iff (rst)
        open_o |=> (credit == '0));
    end else begin : g_mo_props
      // R1: reset clears the release register
      p_reset_clears_r1: assert property (@(posedge clk) rst |=> !open_o);
      // R2: release mirrors the price level
      p_open_matches_full_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (open_o == (credit == FULL)));
      // R5: one-cycle pulse
      p_open_single_r5: assert property (@(posedge clk) disable iff (rst)
        open_o |=> !open_o);
    end
  endgenerate
endmodule

// File: tb/tb_vend_ctrl.sv
module tb_vend_ctrl;
  localparam int CLK_NS = 8;
  localparam int NV = 29;
  // {nickel, dime, expected state-form open, expected transition-form open}
  localparam logic [3:0] VEC [0:NV-1] = '{
    4'b1000, 4'b1000, 4'b1001, 4'b0010,            // 0-3  three 5c, pulse
    4'b0100, 4'b1001, 4'b0010,                     // 4-6  10c then 5c
    4'b1000, 4'b0101, 4'b0010,                     // 7-9  5c then 10c
    4'b0100, 4'b0101, 4'b0010,                     // 10-12 overpay
    4'b0100, 4'b0000, 4'b0000, 4'b1001,            // 13-16 idle gaps hold
    4'b1010, 4'b1000,                              // 17-18 coin in release cycle
    4'b1100, 4'b0101,                              // 19-20 clash then 10c
    4'b0110, 4'b0000,                              // 21-22 coin in release cycle
    4'b1001, 4'b0000, 4'b1000, 4'b1000, 4'b1011,   // 23-27
    4'b0000                                        // 28
  };

  logic clk = 1'b0;
  logic rst, nickel, dime;
  logic mo_open, ml_open;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  vend_ctrl #(.MEALY_OUT(1'b0)) dut (
    .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .open_o(mo_open));
  vend_ctrl #(.MEALY_OUT(1'b1)) dut_ml (
    .clk(clk), .rst(rst), .nickel(nickel), .dime(dime), .open_o(ml_open));

  task automatic check(input string req, input string form, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s (%s form): open=%0b expected %0b at %0t", req, form, act, exp, $time);
    end
  endtask

  task automatic apply(input logic n, input logic d);
    @(negedge clk);
    nickel = n;
    dime   = d;
    #1;
  endtask

  function automatic string vtag(input int i);
    if (i <= 2)  return "R2";
    if (i == 3)  return "R5";
    if (i <= 9)  return "R3";
    if (i <= 12) return "R4";
    if (i <= 16) return "R9";
    if (i <= 18) return "R6";
    if (i <= 20) return "R7";
    if (i <= 22) return "R6";
    return "R10";
  endfunction

  initial begin
    rst = 1'b1; nickel = 1'b0; dime = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "state", mo_open, 1'b0);
    check("R1", "transition", ml_open, 1'b0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][3], VEC[i][2]);
      check(vtag(i), "state", mo_open, VEC[i][1]);
      check($sformatf("R8/%s", vtag(i)), "transition", ml_open, VEC[i][0]);
    end

    // R1: reset arrives with a completing coin at 10c credit
    apply(1'b0, 1'b1);
    @(negedge clk);
    rst = 1'b1; nickel = 1'b1; dime = 1'b0;
    #1;
    check("R1", "transition", ml_open, 1'b0);
    check("R1", "state", mo_open, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1", "transition", ml_open, 1'b0); // credit 0 + 5c
    apply(1'b1, 1'b0);
    check("R1", "transition", ml_open, 1'b0);
    apply(1'b1, 1'b0);
    check("R1", "transition", ml_open, 1'b1);
    check("R1", "state", mo_open, 1'b0);
    apply(1'b0, 1'b0);
    check("R1", "state", mo_open, 1'b1);
    apply(1'b0, 1'b0);
    check("R5", "state", mo_open, 1'b0);

    // R1: reset while the state form is about to release
    apply(1'b0, 1'b1);
    apply(1'b0, 1'b1);
    check("R4", "transition", ml_open, 1'b1);
    @(negedge clk);
    rst = 1'b1; nickel = 1'b0; dime = 1'b0;
    #1;
    check("R1", "state", mo_open, 1'b1);
    @(negedge clk);
    #1;
    check("R1", "state", mo_open, 1'b0);
    rst = 1'b0;
    apply(1'b0, 1'b1);
    apply(1'b1, 1'b0);
    check("R3", "transition", ml_open, 1'b1);
    apply(1'b0, 1'b0);
    check("R3", "state", mo_open, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule